// File: doc/BRIEF.md
# Interrupt Controller Configuration and Bus Clock Generator

This block holds one 8-bit read-write configuration byte for an I/O interrupt controller and turns its fields straight into control. One bit decides whether the controller's memory window is claimed locally or handed to the legacy I/O side, and whether the interrupt message bus is in use. Two bits move the power-management SMI and SCI outputs onto interrupt inputs 23 and 22. When they do, the SMI pin is silenced or the separate SCI-select function is disabled. When they do not, those two interrupt inputs follow two general-purpose input paths.

A two-bit field picks the interrupt-bus clock. It can be the PCI clock divided by four, the PCI clock divided by two, or the PCI clock passed through, and in all three cases the block drives the pin. The fourth code releases the pin to an external source of at most 33.3 MHz. A new clock choice is applied only at the start of a divided-clock period, so no shortened high or low phase reaches the pin.

Top module: `intc_cfg_clkgen`

## Requirements
- R1: The configuration byte resets to 00h. A write stores bits [4:0], which read back unchanged. Bits [7:5] always read 0 and ignore the written value.
- R2: With bit 0 clear, a window hit (`mem_win_hit`=1) raises `mem_forward` and leaves `mem_claim` low, and `msg_bus_en` is 0. With bit 0 set, the same hit raises `mem_claim` and leaves `mem_forward` low, and `msg_bus_en` is 1.
- R3: With bit 1 set, `irq23` equals `pm_smi` and `smi_assert` stays 0. With bit 1 clear, `irq23` equals `gpio17_in` and `smi_assert` equals `pm_smi`. Changes take effect in the cycle after the write edge.
- R4: With bit 2 set, `irq22` equals `pm_sci` and `sci_sel_off` is 1. With bit 2 clear, `irq22` equals `gpio16_in` and `sci_sel_off` is 0.
- R5: With clock-select bits [4:3]=00, `bus_clk_out` is a registered clock with a period of 4 PCI cycles: 2 cycles high, then 2 low. With 01 it has a period of 2: 1 high, then 1 low. In both cases `bus_clk_oe` is 1.
- R6: With clock-select 10, `bus_clk_out` follows the PCI clock itself and `bus_clk_oe` is 1.
- R7: With clock-select 11, `bus_clk_oe` is 0 and `bus_clk_out` is held at 0.
- R8: A new clock-select value is taken over only at the start of a divided-clock period, so the period that is running finishes first. For example, a write of 01 that lands one cycle into a divide-by-4 high phase gives the samples 1,0,0 and then 1,0,1.
- R9: Reset clears the divider. At the first clock edge after reset is released, a divide-by-4 period starts with its high phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | PCI clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_rdata | output | 8 | Configuration byte read-back |
| pm_smi | input | 1 | SMI output of power management |
| pm_sci | input | 1 | SCI output of power management |
| gpio16_in | input | 1 | General-purpose input path for interrupt 22 |
| gpio17_in | input | 1 | General-purpose input path for interrupt 23 |
| mem_win_hit | input | 1 | Memory access falls in the controller window |
| mem_claim | output | 1 | Claim the access locally |
| mem_forward | output | 1 | Forward the access to the legacy I/O side |
| msg_bus_en | output | 1 | Interrupt message bus in use |
| irq22 | output | 1 | Interrupt request input 22 |
| irq23 | output | 1 | Interrupt request input 23 |
| smi_assert | output | 1 | Assert the SMI pin (active high request) |
| sci_sel_off | output | 1 | Disable the SCI-select function |
| bus_clk_out | output | 1 | Interrupt-bus clock |
| bus_clk_oe | output | 1 | Output enable for the interrupt-bus clock pin |

## Verification
Two events can fall in the same cycle: a write that flips SMI redirection, and an active `pm_smi` that must end up on exactly one of `irq23` and `smi_assert`. The bench holds `pm_smi` high with `gpio17_in` low and lets the redirection write land on one edge. It checks the pair just before that edge and just after it, and an assertion requires, in every cycle, that exactly one of the two carries the event. The second overlap is a clock-select write landing in the middle of a divide-by-4 high phase. It is judged by sampling the clock cycle by cycle against the sequence in which the old period finishes first.

// File: rtl/intc_cfg_clkgen.sv
module intc_cfg_clkgen (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_we,
  input  logic [7:0] cfg_wdata,
  output logic [7:0] cfg_rdata,
  input  logic       pm_smi,
  input  logic       pm_sci,
  input  logic       gpio16_in,
  input  logic       gpio17_in,
  input  logic       mem_win_hit,
  output logic       mem_claim,
  output logic       mem_forward,
  output logic       msg_bus_en,
  output logic       irq22,
  output logic       irq23,
  output logic       smi_assert,
  output logic       sci_sel_off,
  output logic       bus_clk_out,
  output logic       bus_clk_oe
);
  localparam logic [1:0] SEL_DIV4 = 2'b00;
  localparam logic [1:0] SEL_DIV2 = 2'b01;
  localparam logic [1:0] SEL_PASS = 2'b10;
  localparam logic [1:0] SEL_EXT  = 2'b11;

  logic [4:0] cfg_q;
  logic [1:0] act_sel;
  logic [1:0] ph;
  logic       div_q;
  logic       boundary;

  always_ff @(posedge clk) begin
    if (!rst_n)      cfg_q <= '0;
    else if (cfg_we) cfg_q <= cfg_wdata[4:0];
  end

  assign cfg_rdata = {3'b000, cfg_q};

  wire ctl_en    = cfg_q[0];
  wire smi_redir = cfg_q[1];
  wire sci_redir = cfg_q[2];

  assign msg_bus_en  = ctl_en;
  assign mem_claim   = mem_win_hit & ctl_en;
  assign mem_forward = mem_win_hit & ~ctl_en;

  assign irq23      = smi_redir ? pm_smi : gpio17_in;
  assign smi_assert = pm_smi & ~smi_redir;
  assign irq22      = sci_redir ? pm_sci : gpio16_in;
  assign sci_sel_off = sci_redir;

  always_comb begin
    case (act_sel)
      SEL_DIV4: boundary = (ph == 2'd3);
      SEL_DIV2: boundary = (ph == 2'd1);
      default:  boundary = 1'b1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_sel <= SEL_DIV4;
      ph      <= 2'd3;
      div_q   <= 1'b0;
    end else if (boundary) begin
      act_sel <= cfg_q[4:3];
      ph      <= 2'd0;
      div_q   <= ~cfg_q[4];
    end else begin
      ph      <= ph + 2'd1;
      div_q   <= (act_sel == SEL_DIV4) && (ph == 2'd0);
    end
  end

  assign bus_clk_oe  = (act_sel != SEL_EXT);
  assign bus_clk_out = (act_sel == SEL_PASS) ? clk :
                       (act_sel == SEL_EXT)  ? 1'b0 : div_q;
endmodule

// File: rtl/intc_cfg_clkgen_chk.sv
module intc_cfg_clkgen_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [7:0] cfg_rdata,
  input logic       pm_smi,
  input logic       pm_sci,
  input logic       gpio17_in,
  input logic       mem_win_hit,
  input logic       mem_claim,
  input logic       mem_forward,
  input logic       irq22,
  input logic       irq23,
  input logic       smi_assert,
  input logic       sci_sel_off,
  input logic       bus_clk_out,
  input logic       bus_clk_oe,
  input logic [1:0] act_sel,
  input logic       div_q
);
  a_r1_rsv_zero: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_rdata[7:5] == 3'b000);

  a_r2_claim_or_forward: assert property (@(posedge clk) disable iff (!rst_n)
    mem_win_hit |-> (mem_claim != mem_forward));

  a_r3_smi_one_path: assert property (@(posedge clk) disable iff (!rst_n)
    (pm_smi && !gpio17_in) |-> (irq23 != smi_assert));

  a_r4_sci_route: assert property (@(posedge clk) disable iff (!rst_n)
    sci_sel_off |-> (irq22 == pm_sci));

  a_r7_ext_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_clk_oe |-> !bus_clk_out);

  a_r8_div4_high_full: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(div_q) && act_sel == 2'b00) |=> div_q);

  a_r8_div4_low_full: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(div_q) && act_sel == 2'b00) |=> !div_q);
endmodule

bind intc_cfg_clkgen intc_cfg_clkgen_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_rdata(cfg_rdata), .pm_smi(pm_smi),
  .pm_sci(pm_sci), .gpio17_in(gpio17_in), .mem_win_hit(mem_win_hit),
  .mem_claim(mem_claim), .mem_forward(mem_forward), .irq22(irq22),
  .irq23(irq23), .smi_assert(smi_assert), .sci_sel_off(sci_sel_off),
  .bus_clk_out(bus_clk_out), .bus_clk_oe(bus_clk_oe),
  .act_sel(act_sel), .div_q(div_q)
);

// File: tb/tb_intc_cfg_clkgen.sv
module tb_intc_cfg_clkgen;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [7:0] cfg_wdata = 8'h00;
  logic pm_smi = 1'b0, pm_sci = 1'b0, gpio16_in = 1'b0, gpio17_in = 1'b0;
  logic mem_win_hit = 1'b0;
  logic [7:0] cfg_rdata;
  logic mem_claim, mem_forward, msg_bus_en, irq22, irq23;
  logic smi_assert, sci_sel_off, bus_clk_out, bus_clk_oe;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  intc_cfg_clkgen dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .pm_smi(pm_smi), .pm_sci(pm_sci),
    .gpio16_in(gpio16_in), .gpio17_in(gpio17_in), .mem_win_hit(mem_win_hit),
    .mem_claim(mem_claim), .mem_forward(mem_forward), .msg_bus_en(msg_bus_en),
    .irq22(irq22), .irq23(irq23), .smi_assert(smi_assert),
    .sci_sel_off(sci_sel_off), .bus_clk_out(bus_clk_out), .bus_clk_oe(bus_clk_oe)
  );

  task automatic chk(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] d);
    @(negedge clk); cfg_we = 1'b1; cfg_wdata = d;
    @(negedge clk); cfg_we = 1'b0;
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic sync_rise();
    logic prev;
    step(); prev = bus_clk_out;
    for (int i = 0; i < 12; i++) begin
      step();
      if (!prev && bus_clk_out) break;
      prev = bus_clk_out;
    end
  endtask

  task automatic t_reset_state();
    chk("R1", "reset rdata", cfg_rdata, 8'h00);
    chk("R2", "reset msg_bus_en", {7'd0, msg_bus_en}, 8'd0);
    chk("R7", "reset oe", {7'd0, bus_clk_oe}, 8'd1);
    chk("R9", "reset clk low", {7'd0, bus_clk_out}, 8'd0);
  endtask

  task automatic t_r9_first_period();
    @(negedge clk); rst_n = 1'b1;
    step(); chk("R9", "k0", {7'd0, bus_clk_out}, 8'd1);
    step(); chk("R9", "k1", {7'd0, bus_clk_out}, 8'd1);
    step(); chk("R9", "k2", {7'd0, bus_clk_out}, 8'd0);
    step(); chk("R9", "k3", {7'd0, bus_clk_out}, 8'd0);
    step(); chk("R9", "k4", {7'd0, bus_clk_out}, 8'd1);
  endtask

  task automatic t_r1_register();
    wr(8'hFF); chk("R1", "rsv ignored", cfg_rdata, 8'h1F);
    wr(8'hA5); chk("R1", "partial", cfg_rdata, 8'h05);
    wr(8'h00); chk("R1", "cleared", cfg_rdata, 8'h00);
  endtask

  task automatic t_r2_enable();
    mem_win_hit = 1'b1;
    wr(8'h00); #1;
    chk("R2", "off claim/fwd/msg", {5'd0, mem_claim, mem_forward, msg_bus_en}, 8'b010);
    wr(8'h01); #1;
    chk("R2", "on claim/fwd/msg", {5'd0, mem_claim, mem_forward, msg_bus_en}, 8'b101);
    mem_win_hit = 1'b0; #1;
    chk("R2", "no hit", {6'd0, mem_claim, mem_forward}, 8'b00);
    wr(8'h00);
  endtask

  task automatic t_r3_smi();
    pm_smi = 1'b0; gpio17_in = 1'b1; #1;
    chk("R3", "gpio17 path irq23", {7'd0, irq23}, 8'd1);
    pm_smi = 1'b1; gpio17_in = 1'b0; #1;
    chk("R3", "pre irq23/smi", {6'd0, irq23, smi_assert}, 8'b01);
    @(negedge clk); cfg_we = 1'b1; cfg_wdata = 8'h02;
    #1.5; chk("R3", "before edge irq23/smi", {6'd0, irq23, smi_assert}, 8'b01);
    @(posedge clk); #1;
    chk("R3", "after edge irq23/smi", {6'd0, irq23, smi_assert}, 8'b10);
    cfg_we = 1'b0;
    gpio17_in = 1'b1; pm_smi = 1'b0; #1;
    chk("R3", "redir ignores gpio17", {6'd0, irq23, smi_assert}, 8'b00);
    pm_smi = 1'b0; gpio17_in = 1'b0;
    wr(8'h00);
  endtask

  task automatic t_r4_sci();
    pm_sci = 1'b1; gpio16_in = 1'b0; #1;
    chk("R4", "gpio path irq22/off", {6'd0, irq22, sci_sel_off}, 8'b00);
    wr(8'h04); #1;
    chk("R4", "redir irq22/off", {6'd0, irq22, sci_sel_off}, 8'b11);
    pm_sci = 1'b0; gpio16_in = 1'b1; #1;
    chk("R4", "redir ignores gpio16", {7'd0, irq22}, 8'd0);
    wr(8'h00); #1;
    chk("R4", "back to gpio16", {6'd0, irq22, sci_sel_off}, 8'b10);
    gpio16_in = 1'b0;
  endtask

  task automatic t_div(input logic [7:0] code, input int n, input string req);
    wr(code);
    repeat (6) step();
    sync_rise();
    for (int k = 1; k < 2 * n; k++) begin
      step();
      chk(req, "div phase", {7'd0, bus_clk_out}, ((k % n) < n / 2) ? 8'd1 : 8'd0);
    end
    chk(req, "div oe", {7'd0, bus_clk_oe}, 8'd1);
  endtask

  task automatic t_r6_pass();
    wr(8'h10);
    repeat (6) step();
    for (int i = 0; i < 3; i++) begin
      @(posedge clk); #1;
      chk("R6", "pass high", {6'd0, bus_clk_out, bus_clk_oe}, 8'b11);
      @(negedge clk); #1;
      chk("R6", "pass low", {6'd0, bus_clk_out, bus_clk_oe}, 8'b01);
    end
  endtask

  task automatic t_r7_ext();
    wr(8'h18);
    repeat (6) step();
    for (int i = 0; i < 4; i++) begin
      #1; chk("R7", "ext out/oe", {6'd0, bus_clk_out, bus_clk_oe}, 8'b00);
      step();
    end
  endtask

  task automatic t_r8_switch();
    logic exp [6] = '{1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1};
    wr(8'h00);
    repeat (6) step();
    sync_rise();
    cfg_we = 1'b1; cfg_wdata = 8'h08;
    for (int k = 0; k < 6; k++) begin
      step();
      cfg_we = 1'b0;
      chk("R8", "switch seq", {7'd0, bus_clk_out}, {7'd0, exp[k]});
    end
  endtask

  task automatic t_r9_midreset();
    wr(8'h08);
    repeat (5) step();
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); @(negedge clk);
    chk("R9", "reset rdata", cfg_rdata, 8'h00);
    t_r9_first_period();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset_state();
    t_r9_first_period();
    t_r1_register();
    t_r2_enable();
    t_r3_smi();
    t_r4_sci();
    t_div(8'h00, 4, "R5");
    t_div(8'h08, 2, "R5");
    t_r6_pass();
    t_r7_ext();
    t_r8_switch();
    t_r9_midreset();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule